// File: doc/BRIEF.md
# Remote DMA Data Port with Completion Interrupt

This block lets a host walk through local packet memory one access at a time through a single data port. The host first loads a 16-bit memory pointer and a 16-bit transfer length into the register file, a byte at a time. Each data-port access then reads or writes one, two or four bytes at the pointer. The pointer moves forward by the access size and the remaining length goes down by the same amount. The pointer follows the receive ring: when a step lands on the ring's stop page, it jumps back to the ring's start page.

When the transfer length runs out, the block sets a completion flag in its status register. A command that asks for a transfer while the length is already zero sets the same flag at once. Status flags are cleared by writing ones to them. A mask register selects which flags drive the interrupt line. The memory is an internal synchronous RAM that covers a small address-PROM area at the bottom of the space and a packet window higher up. Accesses outside those two areas do nothing on write and return all ones on read.

Top module: `rdma_port`

## Requirements
- R1: After reset the status register reads 0x80, the interrupt output is low, and the pointer and length both read 0.
- R2: The host loads the pointer low byte at register 3, the pointer high byte at register 4, the length low byte at register 5 and the length high byte at register 6. A read of the same register returns the current value. Register reads appear on `reg_rdata` one clock after the address is presented.
- R3: With configuration register 9 bit 0 clear, each data-port access is one byte: the pointer goes up by 1 and the length goes down by 1. With that bit set, each access is 16 bits and both change by 2.
- R4: An access with `dp_long` high moves 4 bytes, whatever the configuration bit says.
- R5: A 16-bit or 32-bit access clears bit 0 of the pointer before it uses the pointer.
- R6: If the advanced pointer equals the stop page (register 2) times 256, it is replaced by the start page (register 1) times 256.
- R7: If the remaining length is less than or equal to the access size, the length becomes 0 and status bit 6 (transfer complete) is set.
- R8: A write to command register 0 with bit 3 (remote read) or bit 4 (remote write) set, while the length is 0, sets status bit 6. The same write with a nonzero length leaves bit 6 unchanged.
- R9: A write to status register 7 clears each of bits 6..0 where the written bit is 1. Bit 7 is not affected by this write. A completion event in the same cycle takes precedence over the clear.
- R10: A command write with bit 0 (stop) clear clears status bit 7. A command write with bit 0 set leaves bit 7 unchanged.
- R11: `irq` is high one clock after (status AND mask register 8 AND 0x7F) becomes nonzero. Status bit 7 never raises it.
- R12: Multi-byte accesses are little-endian: data bits 7:0 go to the lowest address. Read data is valid on `dp_rdata` one clock after the request. Lanes beyond the access size read as 0.
- R13: Each byte lane reaches memory only if its address is below PROM_BYTES or lies in the range from WIN_BASE to WIN_BASE+WIN_BYTES. Outside those ranges a write lane is dropped and a read lane returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered readback of the selected register |
| dp_req | input | 1 | One data-port access this cycle |
| dp_wr | input | 1 | 1 for a write access, 0 for a read access |
| dp_long | input | 1 | 32-bit access |
| dp_wdata | input | 32 | Write data, little-endian lanes |
| dp_rdata | output | 32 | Registered read data |
| irq | output | 1 | Masked interrupt, registered |

## Verification
The bench builds the block with WIN_BASE at 0x4000 and WIN_BYTES lowered to 256. This puts the top edge of the packet window at 0x40FF/0x4100, the same place as a ring that runs from page 0x40 to page 0x41. With that setting, one 32-bit access can straddle the valid and invalid regions, so the per-lane all-ones fill can be observed. The same setting lets both byte and word steps reach the stop-page wrap. The PROM area keeps its default of 32 bytes, so a word read at 0x20 shows that an access just past the PROM returns all ones.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  // command register bit positions
  localparam int CMD_STOP = 0;
  localparam int CMD_RRD  = 3;
  localparam int CMD_RWR  = 4;
  // status register bit positions
  localparam int ST_DONE  = 6;
  localparam int ST_RESET = 7;

  typedef enum logic [3:0] {
    RA_CMD     = 4'd0,
    RA_PSTART  = 4'd1,
    RA_PSTOP   = 4'd2,
    RA_PTR_LO  = 4'd3,
    RA_PTR_HI  = 4'd4,
    RA_LEN_LO  = 4'd5,
    RA_LEN_HI  = 4'd6,
    RA_STATUS  = 4'd7,
    RA_MASK    = 4'd8,
    RA_CFG     = 4'd9
  } reg_sel_e;
endpackage

// File: rtl/rdma_mem.sv
module rdma_mem #(
  parameter int AW         = 16,
  parameter int PROM_BYTES = 32,
  parameter int WIN_BASE   = 16'h4000,
  parameter int WIN_BYTES  = 1024,
  parameter int LANES      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [2:0]         nbytes,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata
);
  localparam int DEPTH = PROM_BYTES + WIN_BYTES;
  localparam int IW    = $clog2(DEPTH);
  localparam logic [AW:0] P_END = (AW+1)'(PROM_BYTES);
  localparam logic [AW:0] W_LO  = (AW+1)'(WIN_BASE);
  localparam logic [AW:0] W_HI  = (AW+1)'(WIN_BASE + WIN_BYTES);

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] idx [LANES];
  logic          ok  [LANES];
  logic          en  [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [AW:0] lx;
      logic [AW:0] off;
      lx     = {1'b0, addr + AW'(i)};
      off    = lx - W_LO + P_END;
      en[i]  = (3'(i) < nbytes);
      ok[i]  = (lx < P_END) || (lx >= W_LO && lx < W_HI);
      idx[i] = (lx < P_END) ? lx[IW-1:0] : off[IW-1:0];
    end
  end

  // storage: no reset, lane writes only
  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (acc && we && en[i] && ok[i]) mem[idx[i]] <= wdata[8*i +: 8];
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (acc && !we) begin
      for (int i = 0; i < LANES; i++) begin
        if (!en[i])     rdata[8*i +: 8] <= 8'h00;
        else if (ok[i]) rdata[8*i +: 8] <= mem[idx[i]];
        else            rdata[8*i +: 8] <= 8'hFF;
      end
    end
  end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_ptr_lo,
  input  logic          ld_ptr_hi,
  input  logic          ld_len_lo,
  input  logic          ld_len_hi,
  input  logic [7:0]    ld_byte,
  input  logic          acc,
  input  logic          wide,
  input  logic [2:0]    nbytes,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  output logic [AW-1:0] cur_ptr,
  output logic [CW-1:0] cur_len,
  output logic [AW-1:0] acc_ptr,
  output logic          done_set
);
  logic [AW-1:0] step_ptr, next_ptr;
  logic          last;

  always_comb begin
    acc_ptr  = wide ? {cur_ptr[AW-1:1], 1'b0} : cur_ptr;
    step_ptr = acc_ptr + AW'(nbytes);
    next_ptr = (step_ptr == ring_stop) ? ring_start : step_ptr;
    last     = (cur_len <= CW'(nbytes));
    done_set = acc && last;
  end

  // an access takes precedence over host loads in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ptr <= '0;
      cur_len <= '0;
    end else if (acc) begin
      cur_ptr <= next_ptr;
      cur_len <= last ? '0 : cur_len - CW'(nbytes);
    end else begin
      if (ld_ptr_lo) cur_ptr[7:0]    <= ld_byte;
      if (ld_ptr_hi) cur_ptr[AW-1:8] <= ld_byte[AW-9:0];
      if (ld_len_lo) cur_len[7:0]    <= ld_byte;
      if (ld_len_hi) cur_len[CW-1:8] <= ld_byte[CW-9:0];
    end
  end
endmodule

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [3:0]    sel,
  input  logic [7:0]    wdata,
  input  logic          done_set,
  input  logic [AW-1:0] cur_ptr,
  input  logic [CW-1:0] cur_len,
  output logic          ld_ptr_lo,
  output logic          ld_ptr_hi,
  output logic          ld_len_lo,
  output logic          ld_len_hi,
  output logic [AW-1:0] ring_start,
  output logic [AW-1:0] ring_stop,
  output logic          cfg_wide,
  output logic [7:0]    status,
  output logic [7:0]    mask,
  output logic [7:0]    rdata,
  output logic          irq
);
  localparam int PW = AW - 8;

  reg_sel_e      rs;
  logic [7:0]    cmd_q, cfg_q, st_n;
  logic [PW-1:0] pg_start_q, pg_stop_q;
  logic          zero_len;

  assign rs         = reg_sel_e'(sel);
  assign ld_ptr_lo  = wr && rs == RA_PTR_LO;
  assign ld_ptr_hi  = wr && rs == RA_PTR_HI;
  assign ld_len_lo  = wr && rs == RA_LEN_LO;
  assign ld_len_hi  = wr && rs == RA_LEN_HI;
  assign ring_start = {pg_start_q, 8'h00};
  assign ring_stop  = {pg_stop_q, 8'h00};
  assign cfg_wide   = cfg_q[0];
  assign zero_len   = wr && rs == RA_CMD && (wdata[CMD_RRD] || wdata[CMD_RWR])
                      && cur_len == '0;

  always_comb begin
    st_n = status;
    if (wr && rs == RA_STATUS) st_n[6:0] = status[6:0] & ~wdata[6:0];
    if (wr && rs == RA_CMD && !wdata[CMD_STOP]) st_n[ST_RESET] = 1'b0;
    if (done_set || zero_len) st_n[ST_DONE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q      <= 8'h01;
      cfg_q      <= '0;
      mask       <= '0;
      pg_start_q <= '0;
      pg_stop_q  <= '0;
      status     <= 8'h80;
      irq        <= 1'b0;
      rdata      <= '0;
    end else begin
      status <= st_n;
      irq    <= |(status & mask & 8'h7F);
      if (wr) begin
        case (rs)
          RA_CMD:    cmd_q      <= wdata;
          RA_PSTART: pg_start_q <= wdata[PW-1:0];
          RA_PSTOP:  pg_stop_q  <= wdata[PW-1:0];
          RA_MASK:   mask       <= wdata;
          RA_CFG:    cfg_q      <= wdata;
          default:   ;
        endcase
      end
      case (rs)
        RA_CMD:    rdata <= cmd_q;
        RA_PSTART: rdata <= 8'(pg_start_q);
        RA_PSTOP:  rdata <= 8'(pg_stop_q);
        RA_PTR_LO: rdata <= cur_ptr[7:0];
        RA_PTR_HI: rdata <= 8'(cur_ptr >> 8);
        RA_LEN_LO: rdata <= cur_len[7:0];
        RA_LEN_HI: rdata <= 8'(cur_len >> 8);
        RA_STATUS: rdata <= status;
        RA_MASK:   rdata <= mask;
        RA_CFG:    rdata <= cfg_q;
        default:   rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int AW         = 16,
  parameter int CW         = 16,
  parameter int PROM_BYTES = 32,
  parameter int WIN_BASE   = 16'h4000,
  parameter int WIN_BYTES  = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        dp_req,
  input  logic        dp_wr,
  input  logic        dp_long,
  input  logic [31:0] dp_wdata,
  output logic [31:0] dp_rdata,
  output logic        irq
);
  logic          ld_ptr_lo, ld_ptr_hi, ld_len_lo, ld_len_hi;
  logic [AW-1:0] start_addr, stop_addr, cur_ptr, acc_ptr;
  logic [CW-1:0] cur_len;
  logic          cfg_wide, wide, done_set;
  logic [2:0]    nbytes;
  logic [7:0]    status_q, mask_q;

  assign wide   = dp_long || cfg_wide;
  assign nbytes = dp_long ? 3'd4 : (cfg_wide ? 3'd2 : 3'd1);

  rdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_addr), .wdata(reg_wdata),
    .done_set(done_set), .cur_ptr(cur_ptr), .cur_len(cur_len),
    .ld_ptr_lo(ld_ptr_lo), .ld_ptr_hi(ld_ptr_hi),
    .ld_len_lo(ld_len_lo), .ld_len_hi(ld_len_hi),
    .ring_start(start_addr), .ring_stop(stop_addr), .cfg_wide(cfg_wide),
    .status(status_q), .mask(mask_q), .rdata(reg_rdata), .irq(irq)
  );

  rdma_engine #(.AW(AW), .CW(CW)) u_engine (
    .clk(clk), .rst(rst),
    .ld_ptr_lo(ld_ptr_lo), .ld_ptr_hi(ld_ptr_hi),
    .ld_len_lo(ld_len_lo), .ld_len_hi(ld_len_hi), .ld_byte(reg_wdata),
    .acc(dp_req), .wide(wide), .nbytes(nbytes),
    .ring_start(start_addr), .ring_stop(stop_addr),
    .cur_ptr(cur_ptr), .cur_len(cur_len), .acc_ptr(acc_ptr),
    .done_set(done_set)
  );

  rdma_mem #(.AW(AW), .PROM_BYTES(PROM_BYTES), .WIN_BASE(WIN_BASE),
             .WIN_BYTES(WIN_BYTES), .LANES(4)) u_mem (
    .clk(clk), .rst(rst), .acc(dp_req), .we(dp_wr), .addr(acc_ptr),
    .nbytes(nbytes), .wdata(dp_wdata), .rdata(dp_rdata)
  );
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [1:0]    xfer_bits,
  input logic          dp_req,
  input logic          dp_long,
  input logic          irq,
  input logic [7:0]    status,
  input logic [7:0]    mask,
  input logic [AW-1:0] cur_ptr,
  input logic [CW-1:0] cur_len,
  input logic [AW-1:0] start_addr,
  input logic [AW-1:0] stop_addr,
  input logic          cfg_wide
);
  p_reset_status_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == 8'h80 && cur_len == '0));

  p_len_step_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(dp_req) && $past(cur_len) > CW'(4)) |->
      (cur_len < $past(cur_len) && cur_len != '0));

  p_even_ptr_r5: assert property (@(posedge clk) disable iff (rst)
    $past(dp_req && (dp_long || cfg_wide) && start_addr[0] == 1'b0) |-> !cur_ptr[0]);

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(dp_req) && $past(start_addr) != $past(stop_addr)) |->
      cur_ptr != $past(stop_addr));

  p_done_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(dp_req) && $past(cur_len) <= CW'(1)) |-> (cur_len == '0 && status[6]));

  p_zero_len_r8: assert property (@(posedge clk) disable iff (rst)
    $past(reg_wr && reg_addr == 4'd0 && xfer_bits != 2'b00 && cur_len == '0)
      |-> status[6]);

  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(status & mask & 8'h7F) == 8'h00) |-> !irq);
endmodule

bind rdma_port rdma_port_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .xfer_bits(reg_wdata[4:3]), .dp_req(dp_req), .dp_long(dp_long), .irq(irq),
  .status(status_q), .mask(mask_q), .cur_ptr(cur_ptr), .cur_len(cur_len),
  .start_addr(start_addr), .stop_addr(stop_addr), .cfg_wide(cfg_wide)
);

// File: tb/test_rdma_port.sv
module test_rdma_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dp_req = 1'b0, dp_wr = 1'b0, dp_long = 1'b0;
  logic [31:0] dp_wdata = '0;
  logic [31:0] dp_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rdma_port #(.WIN_BASE(16'h4000), .WIN_BYTES(256)) i_rdma_port (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_req(dp_req),
    .dp_wr(dp_wr), .dp_long(dp_long), .dp_wdata(dp_wdata),
    .dp_rdata(dp_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wreg(4'd3, p[7:0]); wreg(4'd4, p[15:8]);
  endtask

  task automatic set_len(input logic [15:0] n);
    wreg(4'd5, n[7:0]); wreg(4'd6, n[15:8]);
  endtask

  task automatic get_ptr(output logic [15:0] p);
    logic [7:0] lo, hi;
    rreg(4'd3, lo); rreg(4'd4, hi);
    p = {hi, lo};
  endtask

  task automatic get_len(output logic [15:0] n);
    logic [7:0] lo, hi;
    rreg(4'd5, lo); rreg(4'd6, hi);
    n = {hi, lo};
  endtask

  task automatic dp_write(input logic lng, input logic [31:0] d);
    dp_req = 1'b1; dp_wr = 1'b1; dp_long = lng; dp_wdata = d;
    @(posedge clk); #1;
    dp_req = 1'b0; dp_wr = 1'b0; dp_long = 1'b0;
  endtask

  task automatic dp_read(input logic lng, output logic [31:0] d);
    dp_req = 1'b1; dp_wr = 1'b0; dp_long = lng;
    @(posedge clk); #1;
    d = dp_rdata;
    dp_req = 1'b0; dp_long = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] s; logic [15:0] v;
    do_reset();
    rreg(4'd7, s); chk("R1 status", 32'(s), 32'h80);
    chk("R1 irq", 32'(irq), 32'h0);
    get_ptr(v); chk("R1 ptr", 32'(v), 32'h0);
    get_len(v); chk("R1 len", 32'(v), 32'h0);
  endtask

  task automatic t_load();
    logic [15:0] v;
    do_reset();
    set_ptr(16'h4034); get_ptr(v); chk("R2 ptr load", 32'(v), 32'h4034);
    set_len(16'h0105); get_len(v); chk("R2 len load", 32'(v), 32'h0105);
  endtask

  task automatic t_byte_word();
    logic [15:0] v; logic [7:0] s; logic [31:0] d;
    do_reset();
    set_ptr(16'h4000); set_len(16'd3);
    dp_write(1'b0, 32'hAA);
    get_ptr(v); chk("R3 byte ptr", 32'(v), 32'h4001);
    get_len(v); chk("R3 byte len", 32'(v), 32'd2);
    dp_write(1'b0, 32'hBB);
    rreg(4'd7, s); chk("R7 not yet done", 32'(s), 32'h80);
    dp_write(1'b0, 32'hCC);
    get_len(v); chk("R7 len zero", 32'(v), 32'd0);
    rreg(4'd7, s); chk("R7 done bit", 32'(s), 32'hC0);
    wreg(4'd9, 8'h01);
    set_ptr(16'h4005); set_len(16'd10);
    dp_write(1'b0, 32'h1122);
    get_ptr(v); chk("R5 R3 word ptr", 32'(v), 32'h4006);
    get_len(v); chk("R3 word len", 32'(v), 32'd8);
    wreg(4'd9, 8'h00);
    set_ptr(16'h4004);
    dp_read(1'b0, d); chk("R12 word low byte", d, 32'h22);
    dp_read(1'b0, d); chk("R12 word high byte", d, 32'h11);
    set_ptr(16'h4000);
    dp_read(1'b0, d); chk("R3 byte readback", d, 32'hAA);
  endtask

  task automatic t_long();
    logic [15:0] v; logic [31:0] d;
    do_reset();
    set_ptr(16'h4011); set_len(16'd40);
    dp_write(1'b1, 32'hDEADBEEF);
    get_ptr(v); chk("R4 R5 long ptr", 32'(v), 32'h4014);
    get_len(v); chk("R4 long len", 32'(v), 32'd36);
    set_ptr(16'h4010);
    dp_read(1'b1, d); chk("R12 long read", d, 32'hDEADBEEF);
    set_ptr(16'h4010);
    dp_read(1'b0, d); chk("R12 lowest byte", d, 32'hEF);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    do_reset();
    wreg(4'd1, 8'h40); wreg(4'd2, 8'h41);
    set_len(16'd100);
    set_ptr(16'h40FF);
    dp_write(1'b0, 32'h1);
    get_ptr(v); chk("R6 byte wrap", 32'(v), 32'h4000);
    wreg(4'd9, 8'h01);
    set_ptr(16'h40FE);
    dp_write(1'b0, 32'h2);
    get_ptr(v); chk("R6 word wrap", 32'(v), 32'h4000);
    dp_write(1'b0, 32'h3);
    get_ptr(v); chk("R6 no wrap", 32'(v), 32'h4002);
  endtask

  task automatic t_range();
    logic [31:0] d;
    do_reset();
    set_len(16'd200);
    set_ptr(16'h0010); dp_write(1'b0, 32'h5A);
    set_ptr(16'h0010); dp_read(1'b0, d); chk("R13 prom area", d, 32'h5A);
    set_ptr(16'h3000); dp_write(1'b0, 32'h77);
    set_ptr(16'h3000); dp_read(1'b0, d); chk("R13 hole read", d, 32'hFF);
    set_ptr(16'h40FE); dp_write(1'b1, 32'h44332211);
    set_ptr(16'h40FE); dp_read(1'b1, d); chk("R13 window edge", d, 32'hFFFF2211);
    wreg(4'd9, 8'h01);
    set_ptr(16'h0020); dp_read(1'b0, d); chk("R13 past prom", d, 32'h0000FFFF);
  endtask

  task automatic t_zero_len();
    logic [7:0] s;
    do_reset();
    wreg(4'd0, 8'h0A);
    rreg(4'd7, s); chk("R8 zero length", 32'(s), 32'h40);
    wreg(4'd7, 8'h40);
    rreg(4'd7, s); chk("R9 clear done", 32'(s), 32'h00);
    set_len(16'd5);
    wreg(4'd0, 8'h12);
    rreg(4'd7, s); chk("R8 nonzero length", 32'(s), 32'h00);
  endtask

  task automatic t_cmd_reset_bit();
    logic [7:0] s;
    do_reset();
    wreg(4'd0, 8'h01);
    rreg(4'd7, s); chk("R10 stop keeps bit7", 32'(s), 32'h80);
    wreg(4'd0, 8'h09);
    rreg(4'd7, s); chk("R10 R8 stop with read", 32'(s), 32'hC0);
    wreg(4'd0, 8'h22);
    rreg(4'd7, s); chk("R10 clear bit7", 32'(s), 32'h40);
  endtask

  task automatic t_status_w1c();
    logic [7:0] s;
    do_reset();
    set_len(16'd1);
    dp_write(1'b0, 32'h0);
    rreg(4'd7, s); chk("R7 single byte done", 32'(s), 32'hC0);
    wreg(4'd7, 8'hFF);
    rreg(4'd7, s); chk("R9 bit7 kept", 32'(s), 32'h80);
  endtask

  task automatic t_irq();
    do_reset();
    wreg(4'd8, 8'hC0);
    @(posedge clk); #1;
    chk("R11 bit7 masked out", 32'(irq), 32'h0);
    set_len(16'd1);
    dp_write(1'b0, 32'h0);
    chk("R11 latency", 32'(irq), 32'h0);
    @(posedge clk); #1;
    chk("R11 irq set", 32'(irq), 32'h1);
    wreg(4'd8, 8'h00);
    @(posedge clk); #1;
    chk("R11 masked off", 32'(irq), 32'h0);
    wreg(4'd8, 8'h40);
    wreg(4'd7, 8'h40);
    @(posedge clk); #1;
    chk("R11 cleared", 32'(irq), 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    t_reset();
    t_load();
    t_byte_word();
    t_long();
    t_wrap();
    t_range();
    t_zero_len();
    t_cmd_reset_bit();
    t_status_w1c();
    t_irq();
    finish_run();
  end
endmodule